// File: doc/BRIEF.md
# General-Purpose I/O Port with Timer Pin Override

This block is an 8-bit bidirectional I/O port. Software reaches it through a small register bus. The bus has an address, a write strobe, write data and combinational read data. Two registers sit on the bus. One is an output latch. The other is a per-pin direction register. Reset clears both, so every pin comes up as an undriven input. The block brings out a per-pin output-enable vector and a per-pin output level vector. It takes the resolved external pin levels back in as a vector.

Timer functions can take over individual pins. Their timing logic lives elsewhere and reaches the port as mode, mask and level inputs. The four single-pin compare channels are numbered 2 to 5 and drive pins 6, 5, 4 and 3. An enabled channel forces its pin to drive, whatever the direction bit says. A multi-pin compare channel can claim any subset of pins 3 to 7 through a 5-bit mask. Where it overlaps a single-pin channel, the single-pin level wins. Pin 3 is shared between compare 5 and a capture input, and a select input picks between them. Pins 0 to 2 stay under direction control at all times.

The capture inputs and the pulse-counter input are taken straight from the pin levels. They see the pin level whether or not the pin is being driven.

Top module: `gpio_timer_port`

## Requirements
- R1: After reset the latch and the direction register are 0x00. Every pin has pin_oe low while no timer input is active, and reads at offsets 0 and 1 both return 0x00.
- R2: Direction bit i set to 1 makes pin i an output (pin_oe[i]=1) and set to 0 makes it an input. The direction register is written and read at offset 1.
- R3: A write at offset 0 always loads the latch. The latch value reaches pin_out[i] only while pin i is a general-purpose output, including latch values written earlier while the pin was an input or timer-owned.
- R4: A read at offset 0 returns, for each bit, pin_out[i] when pin_oe[i]=1 and pin_in[i] when pin_oe[i]=0.
- R5: Compare channel k (k=2..5) uses cmp_mode[2(k-2)+1:2(k-2)] and cmp_level[k-2], and owns pin 8-k. A field value of 2'b00 disconnects the channel. Any other value forces pin_oe high and drives cmp_level.
- R6: Mask bit mp_mask[j] (j=0..4) gives the multi-pin channel pin j+3, which then has pin_oe high and drives mp_level[j].
- R7: When a single-pin channel and the multi-pin channel both own a pin, pin_out takes the single-pin channel's level.
- R8: With cap4_sel=1, compare channel 5 cannot drive pin 3, whatever its mode field says. The multi-pin channel still can.
- R9: Pins 0 to 2 follow only the direction register and latch, whatever the timer inputs do. cap_pin[0], [1], [2] and [3] always equal pin_in[2], pin_in[1], pin_in[0] and pin_in[3].
- R10: pc_pin always equals pin_in[7], including while pin 7 is driven by the multi-pin channel or as a general-purpose output.
- R11: A write at any offset other than 0 or 1 changes neither register, and a read at such an offset returns 0x00.
- R12: While a timer channel owns a pin, a write at offset 0 leaves pin_out for that pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_mode | input | 8 | Four 2-bit enable fields for compare channels 2..5 |
| cmp_level | input | 4 | Output levels of compare channels 2..5 |
| mp_mask | input | 5 | Multi-pin channel ownership of pins 3..7 |
| mp_level | input | 5 | Multi-pin channel levels for pins 3..7 |
| cap4_sel | input | 1 | 1: pin 3 serves capture 4, compare 5 blocked |
| pin_in | input | 8 | Resolved external pin levels |
| pin_out | output | 8 | Driver input level per pin |
| pin_oe | output | 8 | Driver enable per pin |
| cap_pin | output | 4 | Capture 1..4 input levels |
| pc_pin | output | 1 | Pulse-counter input level |

## Verification
Two events can land in the same cycle: a latch write and a timer taking or holding a pin. The bench provokes this by writing the latch while compare and mask inputs own pins. It then releases those pins while the direction bit is set, and the earlier latch value must appear. Both channel kinds are also enabled on the same pin to judge priority. A behavioural model, recomputed from the bench's own register copies on every falling edge, judges pin_oe, pin_out, the capture and pulse-counter levels, and the read data.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int PORT_W  = 8;
  localparam int CMP_CH  = 4;
  localparam int MP_W    = 5;
  localparam int MP_BASE = 3;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_NONE  = 2'd2
  } reg_sel_e;

  // A compare mode field enables the channel for any non-zero value
  function automatic logic field_on(input logic [1:0] f);
    return f != 2'b00;
  endfunction

  // Pin served by single-pin compare channel index c (channel c+2)
  function automatic int cmp_pin(input int c);
    return (PORT_W - 2) - c;
  endfunction

  // Read value: driver level where driving, pad level elsewhere
  function automatic logic [PORT_W-1:0] read_mix(
    input logic [PORT_W-1:0] oe,
    input logic [PORT_W-1:0] drv,
    input logic [PORT_W-1:0] pad
  );
    return (oe & drv) | (~oe & pad);
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output reg_sel_e          sel,
  output logic              wr_latch_evt,
  output logic              wr_dir_evt,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q
);

  localparam logic [ADDR_W-1:0] LATCH_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DIR_A   = ADDR_W'(DIR_OFS);

  always_comb begin
    if (bus_addr == LATCH_A)    sel = SEL_LATCH;
    else if (bus_addr == DIR_A) sel = SEL_DIR;
    else                        sel = SEL_NONE;
  end

  assign wr_latch_evt = bus_wr && (sel == SEL_LATCH);
  assign wr_dir_evt   = bus_wr && (sel == SEL_DIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch_evt) latch_q <= bus_wdata;
      if (wr_dir_evt)   dir_q   <= bus_wdata;
    end
  end

endmodule

// File: rtl/gpio_timer_own.sv
module gpio_timer_own
  import gpio_port_pkg::*;
(
  input  logic [2*CMP_CH-1:0] cmp_mode,
  input  logic [CMP_CH-1:0]   cmp_level,
  input  logic [MP_W-1:0]     mp_mask,
  input  logic [MP_W-1:0]     mp_level,
  input  logic                cap4_sel,
  output logic [PORT_W-1:0]   own_single,
  output logic [PORT_W-1:0]   own_multi,
  output logic [PORT_W-1:0]   tmr_own,
  output logic [PORT_W-1:0]   tmr_level
);

  logic [PORT_W-1:0] single_lvl;
  logic [PORT_W-1:0] multi_lvl;

  // Single-pin compare channels
  for (genvar c = 0; c < CMP_CH; c++) begin : g_cmp
    localparam int P = cmp_pin(c);
    if (P == MP_BASE) begin : g_shared
      assign own_single[P] = field_on(cmp_mode[2*c +: 2]) && !cap4_sel;
    end else begin : g_plain
      assign own_single[P] = field_on(cmp_mode[2*c +: 2]);
    end
    assign single_lvl[P] = cmp_level[c];
  end

  // Pins outside compare-channel reach
  for (genvar p = 0; p < PORT_W; p++) begin : g_fill
    if (p < MP_BASE || p > cmp_pin(0)) begin : g_none
      assign own_single[p] = 1'b0;
      assign single_lvl[p] = 1'b0;
    end
  end

  // Multi-pin compare channel
  for (genvar p = 0; p < PORT_W; p++) begin : g_multi
    if (p >= MP_BASE) begin : g_reach
      assign own_multi[p] = mp_mask[p-MP_BASE];
      assign multi_lvl[p] = mp_level[p-MP_BASE];
    end else begin : g_low
      assign own_multi[p] = 1'b0;
      assign multi_lvl[p] = 1'b0;
    end
  end

  assign tmr_own   = own_single | own_multi;
  assign tmr_level = (own_single & single_lvl) | (~own_single & multi_lvl);

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic [PORT_W-1:0] latch_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] tmr_own,
  input  logic [PORT_W-1:0] tmr_level,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] rd_port
);

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    always_comb begin
      if (tmr_own[p]) begin
        pin_oe[p]  = 1'b1;
        pin_out[p] = tmr_level[p];
      end else begin
        pin_oe[p]  = dir_q[p];
        pin_out[p] = latch_q[p];
      end
    end
  end

  assign rd_port = read_mix(pin_oe, pin_out, pin_in);

endmodule

// File: rtl/gpio_timer_port.sv
module gpio_timer_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        cmp_mode,
  input  logic [3:0]        cmp_level,
  input  logic [4:0]        mp_mask,
  input  logic [4:0]        mp_level,
  input  logic              cap4_sel,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe,
  output logic [3:0]        cap_pin,
  output logic              pc_pin
);

  reg_sel_e          sel;
  logic              wr_latch_evt;
  logic              wr_dir_evt;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] own_single;
  logic [PORT_W-1:0] own_multi;
  logic [PORT_W-1:0] tmr_own;
  logic [PORT_W-1:0] tmr_level;
  logic [PORT_W-1:0] rd_port;

  gpio_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_OFS(DATA_OFS),
    .DIR_OFS (DIR_OFS)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .sel         (sel),
    .wr_latch_evt(wr_latch_evt),
    .wr_dir_evt  (wr_dir_evt),
    .latch_q     (latch_q),
    .dir_q       (dir_q)
  );

  gpio_timer_own u_own (
    .cmp_mode  (cmp_mode),
    .cmp_level (cmp_level),
    .mp_mask   (mp_mask),
    .mp_level  (mp_level),
    .cap4_sel  (cap4_sel),
    .own_single(own_single),
    .own_multi (own_multi),
    .tmr_own   (tmr_own),
    .tmr_level (tmr_level)
  );

  gpio_pin_mux u_mux (
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .tmr_own  (tmr_own),
    .tmr_level(tmr_level),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .rd_port  (rd_port)
  );

  always_comb begin
    unique case (sel)
      SEL_LATCH: bus_rdata = rd_port;
      SEL_DIR:   bus_rdata = dir_q;
      default:   bus_rdata = '0;
    endcase
  end

  // Capture 1..3 on pins 2..0, capture 4 on pin 3: always the pad level
  assign cap_pin = {pin_in[3], pin_in[0], pin_in[1], pin_in[2]};
  assign pc_pin  = pin_in[7];

endmodule

// File: rtl/gpio_timer_port_chk.sv
module gpio_timer_port_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [3:0]        cmp_level,
  input logic              cap4_sel,
  input logic [7:0]        pin_in,
  input logic [7:0]        pin_out,
  input logic [7:0]        pin_oe,
  input logic              pc_pin,
  input logic [7:0]        latch_q,
  input logic [7:0]        dir_q,
  input logic [7:0]        own_single,
  input logic [7:0]        own_multi
);

  // R2
  dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & ~pin_oe) == 8'h00);

  // R9
  low_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[2:0] == dir_q[2:0]);

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(DATA_OFS)) |=> latch_q == $past(bus_wdata));

  // R11
  void_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(DATA_OFS) && bus_addr != ADDR_W'(DIR_OFS)) |-> bus_rdata == 8'h00);

  // R7
  single_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_single[4] && own_multi[4]) |-> pin_out[4] == cmp_level[2]);

  // R8
  cap4_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap4_sel |-> !own_single[3]);

  // R10
  pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_pin == pin_in[7]);

endmodule

bind gpio_timer_port gpio_timer_port_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_OFS(DATA_OFS),
  .DIR_OFS (DIR_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cmp_level (cmp_level),
  .cap4_sel  (cap4_sel),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pc_pin    (pc_pin),
  .latch_q   (latch_q),
  .dir_q     (dir_q),
  .own_single(own_single),
  .own_multi (own_multi)
);

// File: tb/gpio_timer_port_tb.sv
module gpio_timer_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] cmp_mode = '0;
  logic [3:0] cmp_level = '0;
  logic [4:0] mp_mask = '0;
  logic [4:0] mp_level = '0;
  logic       cap4_sel = 1'b0;
  logic [7:0] ext_lvl = '0;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [3:0] cap_pin;
  logic       pc_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Model copies of the two registers
  logic [7:0] m_latch = '0;
  logic [7:0] m_dir   = '0;

  always #10 clk = ~clk;

  // Board: a driven pin reads back its own level, others see ext_lvl
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_timer_port u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cmp_mode (cmp_mode),
    .cmp_level(cmp_level),
    .mp_mask  (mp_mask),
    .mp_level (mp_level),
    .cap4_sel (cap4_sel),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .cap_pin  (cap_pin),
    .pc_pin   (pc_pin)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch <= '0;
      m_dir   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == 4'd0) m_latch <= bus_wdata;
      else if (bus_addr == 4'd1) m_dir <= bus_wdata;
    end
  end

  // Per-pin reference: who drives, at what level
  function automatic void model_pins(output logic [7:0] oe, output logic [7:0] lv);
    for (int p = 0; p < 8; p++) begin
      int t;
      t = -1;
      if (p >= 3 && mp_mask[p-3]) t = int'(mp_level[p-3]);
      if (p >= 3 && p <= 6) begin
        int ch;
        ch = 6 - p;
        if (cmp_mode[2*ch +: 2] != 2'b00 && !(p == 3 && cap4_sel))
          t = int'(cmp_level[ch]);
      end
      if (t >= 0) begin
        oe[p] = 1'b1;
        lv[p] = (t != 0);
      end else begin
        oe[p] = m_dir[p];
        lv[p] = m_latch[p];
      end
    end
  endfunction

  function automatic logic [7:0] model_read();
    logic [7:0] oe;
    logic [7:0] lv;
    logic [7:0] r;
    model_pins(oe, lv);
    case (bus_addr)
      4'd0: for (int p = 0; p < 8; p++) r[p] = oe[p] ? lv[p] : ext_lvl[p];
      4'd1: r = m_dir;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] oe;
      logic [7:0] lv;
      model_pins(oe, lv);
      chk("R2 R5 R6 R8 oe", pin_oe, oe);
      chk("R3 R7 R12 out", pin_out & pin_oe, lv & oe);
      chk("R9 cap", {4'h0, cap_pin}, {4'h0, pin_in[3], pin_in[0], pin_in[1], pin_in[2]});
      chk("R10 pc", {7'h0, pc_pin}, {7'h0, pin_in[7]});
      chk("R4 R11 rd", bus_rdata, model_read());
    end
  end

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    settle();
    bus_wr    = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, input string tag, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) settle();
    rst_n = 1'b1;
    settle();

    // R1: reset state
    bread(4'd0, "R1 latch read", 8'h00);
    bread(4'd1, "R1 dir read", 8'h00);
    chk("R1 oe", pin_oe, 8'h00);

    // R2: direction
    bwrite(4'd1, 8'hF0);
    bread(4'd1, "R2 dir read", 8'hF0);
    chk("R2 oe", pin_oe, 8'hF0);

    // R3 and R4: latch drive and mixed read
    bwrite(4'd0, 8'h5A);
    chk("R3 out", pin_out & pin_oe, 8'h50);
    ext_lvl = 8'h0F;
    bread(4'd0, "R4 mixed read", 8'h5F);
    bwrite(4'd1, 8'hFF);
    chk("R3 stored latch", pin_out, 8'h5A);
    bwrite(4'd1, 8'h00);

    // R5: channel 2 on pin 6, channel 5 on pin 3
    cmp_mode = 8'b10_00_00_01;
    cmp_level = 4'b1001;
    #1;
    chk("R5 oe", pin_oe, 8'h48);
    chk("R5 out", pin_out & pin_oe, 8'h48);

    // R8: capture select blocks channel 5
    cap4_sel = 1'b1;
    #1;
    chk("R8 oe", pin_oe, 8'h40);
    cap4_sel = 1'b0;
    cmp_mode = 8'h00;

    // R6: multi-pin channel on pins 3, 4, 7
    mp_mask = 5'b10011;
    mp_level = 5'b10001;
    #1;
    chk("R6 oe", pin_oe, 8'h98);
    chk("R6 out", pin_out & pin_oe, 8'h88);
    chk("R10 pc high", {7'h0, pc_pin}, 8'h01);
    mp_level = 5'b00001;
    #1;
    chk("R10 pc low", {7'h0, pc_pin}, 8'h00);

    // R7: both channels on pin 4
    mp_mask = 5'b00010;
    mp_level = 5'b00010;
    cmp_mode = 8'b00_11_00_00;
    cmp_level = 4'b0000;
    bwrite(4'd1, 8'h10);
    chk("R7 pin4 level", {7'h0, pin_out[4]}, 8'h00);

    // R12: latch write while timer owns pin 4, same cycle as ownership
    bwrite(4'd0, 8'hFF);
    chk("R12 pin4 held", {7'h0, pin_out[4]}, 8'h00);
    cmp_mode = 8'h00;
    mp_mask = 5'b00000;
    #1;
    chk("R3 released pin4", {7'h0, pin_out[4]}, 8'h01);

    // R9: low pins ignore timers
    bwrite(4'd1, 8'h05);
    bwrite(4'd0, 8'h05);
    cmp_mode = 8'hFF;
    mp_mask = 5'b11111;
    ext_lvl = 8'h02;
    #1;
    chk("R9 low oe", {5'h0, pin_oe[2:0]}, 8'h05);
    chk("R9 cap", {5'h0, cap_pin[2:0]}, 8'h07);
    cmp_mode = 8'h00;
    mp_mask = 5'b00000;

    // R10: general-purpose output on pin 7
    bwrite(4'd1, 8'h80);
    bwrite(4'd0, 8'h80);
    chk("R10 pc gp", {7'h0, pc_pin}, 8'h01);

    // R11: unmapped offsets
    bwrite(4'd2, 8'hFF);
    bwrite(4'd7, 8'h3C);
    bread(4'd1, "R11 dir kept", 8'h80);
    bread(4'd0, "R11 latch kept", 8'h80 | (8'h7F & ext_lvl));
    bread(4'd3, "R11 void read", 8'h00);

    settle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule